// File: doc/BRIEF.md
# Nonvolatile Control Decoder with Retrigger Guard

This block sits in front of a nonvolatile-backed static memory. It turns four active-low control pins into commands: chip select, output enable, write strobe and nonvolatile select. The pins are sampled on the system clock through a synchronizer. From them the block decodes SRAM read, SRAM write, standby and no-operation, plus the two transfer requests. A save request copies the array into nonvolatile cells. A restore request copies nonvolatile data back into the array.

The transfer requests are edge-like. Each is a single-cycle pulse, issued only in the cycle in which the synchronized pins first enter the request state. If the pins are held in that state, nothing more is issued. This still holds after the transfer engine finishes. The pins must leave the state and come back before a new request can fire.

A digital supply-good input can block save requests. A busy input from the transfer engine masks every command and forces the data bus off.

Top module: `nvdec_ctrl`

## Requirements
- R1: With chip select high (`ce_n_i`=1), `standby_o` is 1 and `rd_o`, `wr_o`, `dq_oe_o`, `store_req_o`, `recall_req_o` are 0, whatever the other pins are.
- R2: Pins ce_n=0, oe_n=0, we_n=1, nv_n=1 give `rd_o`=1 and `dq_oe_o`=1.
- R3: Pins ce_n=0, we_n=0, nv_n=1 give `wr_o`=1 and `dq_oe_o`=0, for either value of oe_n.
- R4: Entering ce_n=0, we_n=0, nv_n=0, oe_n=1 with `supply_ok_i`=1 and not busy gives a `store_req_o` pulse exactly one cycle wide. `bus_off_o` is 1 in that cycle.
- R5: Entering ce_n=0, oe_n=0, nv_n=0, we_n=1 gives a one-cycle `recall_req_o` pulse. The two request outputs are never high together. With ce_n=0, nv_n=0 and oe_n=1, pulling we_n low selects save, not restore.
- R6: Holding the pins in a request state gives no further pulse, even after `busy_i` falls. Leaving the state and entering it again gives a new pulse.
- R7: With `supply_ok_i`=0, entering the save state issues no save request. A restore request is still issued.
- R8: While `busy_i`=1, `rd_o`, `wr_o` and `dq_oe_o` are 0, `bus_off_o` is 1, and pin changes issue no request.
- R9: A pin change shows on `rd_o`/`wr_o` after the second rising clock edge. A request pulse appears after the third rising edge and not before.
- R10: With ce_n=0, the pattern nv_n=0 with oe_n and we_n equal, or nv_n=1 with oe_n=1 and we_n=1, gives no operation. In that case `standby_o`, `rd_o`, `wr_o` and both requests are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_n_i | input | 1 | Chip select, active low |
| oe_n_i | input | 1 | Output enable, active low |
| we_n_i | input | 1 | Write strobe, active low |
| nv_n_i | input | 1 | Nonvolatile select, active low |
| supply_ok_i | input | 1 | Supply above switch threshold |
| busy_i | input | 1 | Transfer engine busy |
| standby_o | output | 1 | Deselected |
| rd_o | output | 1 | SRAM read command |
| wr_o | output | 1 | SRAM write command |
| store_req_o | output | 1 | One-cycle save request |
| recall_req_o | output | 1 | One-cycle restore request |
| dq_oe_o | output | 1 | Data bus drive enable |
| bus_off_o | output | 1 | Data bus forced off |

## Verification
Directed pin patterns are applied for read, for write with both output-enable values, for save, for restore, for both no-operation encodings, and for deselect with the other pins low. Together these show that each pin takes part in the decode. Moving from restore straight into save checks the write-strobe priority. Holding a request state across a busy window, and then leaving and re-entering it, separates entry triggering from level triggering. Repeating save and restore with the supply low shows that only the save is gated. Sampling one cycle before and at the expected edge pins down the synchronizer latency.

// File: rtl/nvdec_pkg.sv
package nvdec_pkg;
  typedef enum logic [2:0] {
    CMD_STANDBY = 3'd0,
    CMD_NOP     = 3'd1,
    CMD_READ    = 3'd2,
    CMD_WRITE   = 3'd3,
    CMD_STORE   = 3'd4,
    CMD_RECALL  = 3'd5
  } cmd_e;

  typedef struct packed {
    logic ce_n;
    logic oe_n;
    logic we_n;
    logic nv_n;
  } pins_t;

  localparam int unsigned PIN_W = $bits(pins_t);
endpackage

// File: rtl/nvdec_sync.sv
module nvdec_sync #(
  parameter int unsigned W       = 4,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) stg[s] <= RST_VAL;
          else         stg[s] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) stg[s] <= RST_VAL;
          else         stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/nvdec_decode.sv
module nvdec_decode
  import nvdec_pkg::*;
(
  input  pins_t pins_i,
  output cmd_e  cmd_o
);
  always_comb begin
    if (pins_i.ce_n) begin
      cmd_o = CMD_STANDBY;
    end else if (pins_i.nv_n) begin
      // SRAM side: write strobe wins, output enable is don't-care
      if (!pins_i.we_n)      cmd_o = CMD_WRITE;
      else if (!pins_i.oe_n) cmd_o = CMD_READ;
      else                   cmd_o = CMD_NOP;
    end else begin
      // nonvolatile side: write strobe low selects save
      if (!pins_i.we_n && pins_i.oe_n)      cmd_o = CMD_STORE;
      else if (pins_i.we_n && !pins_i.oe_n) cmd_o = CMD_RECALL;
      else                                  cmd_o = CMD_NOP;
    end
  end
endmodule

// File: rtl/nvdec_trig.sv
module nvdec_trig
  import nvdec_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  cmd_e cmd_i,
  input  logic busy_i,
  input  logic supply_ok_i,
  output logic store_req_o,
  output logic recall_req_o
);
  cmd_e prev_q;
  logic store_q, recall_q;
  logic enter_store, enter_recall;

  // previous state tracks pins even while busy, so a held state cannot retrigger
  assign enter_store  = (cmd_i == CMD_STORE)  && (prev_q != CMD_STORE);
  assign enter_recall = (cmd_i == CMD_RECALL) && (prev_q != CMD_RECALL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q   <= CMD_STANDBY;
      store_q  <= 1'b0;
      recall_q <= 1'b0;
    end else begin
      prev_q   <= cmd_i;
      store_q  <= enter_store && !busy_i && supply_ok_i;
      recall_q <= enter_recall && !busy_i;
    end
  end

  assign store_req_o  = store_q;
  assign recall_req_o = recall_q;

  // R4
  store_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_req_o |=> !store_req_o);
  // R5
  recall_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recall_req_o |=> !recall_req_o);
  // R5
  req_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({store_req_o, recall_req_o}));
  // R7
  store_supply_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_req_o |-> $past(supply_ok_i));
  // R8
  req_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (store_req_o || recall_req_o) |-> !$past(busy_i));
endmodule

// File: rtl/nvdec_ctrl.sv
module nvdec_ctrl
  import nvdec_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_n_i,
  input  logic oe_n_i,
  input  logic we_n_i,
  input  logic nv_n_i,
  input  logic supply_ok_i,
  input  logic busy_i,
  output logic standby_o,
  output logic rd_o,
  output logic wr_o,
  output logic store_req_o,
  output logic recall_req_o,
  output logic dq_oe_o,
  output logic bus_off_o
);
  pins_t pins_raw, pins_s;
  cmd_e  cmd;

  assign pins_raw = '{ce_n: ce_n_i, oe_n: oe_n_i, we_n: we_n_i, nv_n: nv_n_i};

  nvdec_sync #(.W(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pins_raw),
    .q_o   (pins_s)
  );

  nvdec_decode u_dec (
    .pins_i(pins_s),
    .cmd_o (cmd)
  );

  nvdec_trig u_trig (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_i       (cmd),
    .busy_i      (busy_i),
    .supply_ok_i (supply_ok_i),
    .store_req_o (store_req_o),
    .recall_req_o(recall_req_o)
  );

  assign standby_o = (cmd == CMD_STANDBY);
  assign rd_o      = (cmd == CMD_READ)  && !busy_i;
  assign wr_o      = (cmd == CMD_WRITE) && !busy_i;
  assign dq_oe_o   = rd_o;
  // cover the gap between request and engine raising busy
  assign bus_off_o = busy_i || store_req_o || recall_req_o;

  // R8
  busy_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> (!dq_oe_o && !rd_o && !wr_o && bus_off_o));
  // R1
  standby_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    standby_o |-> (!dq_oe_o && !rd_o && !wr_o));
  // R3
  write_no_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |-> !dq_oe_o);
  // R4
  req_bus_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (store_req_o || recall_req_o) |-> (bus_off_o && !dq_oe_o));
endmodule

// File: tb/sim_nvdec_ctrl.sv
`timescale 1ns/1ps
module sim_nvdec_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, nv_n = 1'b1;
  logic supply_ok = 1'b1, busy = 1'b0;
  logic standby, rd, wr, sreq, rreq, dq_oe, bus_off;
  int   n_tests = 0, n_fail = 0;
  int   store_cnt = 0, recall_cnt = 0;

  always #2.5 clk = ~clk;

  nvdec_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .ce_n_i(ce_n), .oe_n_i(oe_n), .we_n_i(we_n),
    .nv_n_i(nv_n), .supply_ok_i(supply_ok), .busy_i(busy), .standby_o(standby),
    .rd_o(rd), .wr_o(wr), .store_req_o(sreq), .recall_req_o(rreq),
    .dq_oe_o(dq_oe), .bus_off_o(bus_off)
  );

  always @(negedge clk) begin
    if (sreq) store_cnt++;
    if (rreq) recall_cnt++;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pins(input logic c, input logic o, input logic w, input logic v);
    ce_n = c; oe_n = o; we_n = w; nv_n = v;
  endtask

  task automatic go_idle();
    pins(1, 1, 1, 1);
    step(4);
  endtask

  task automatic t_reset();
    chk("R1 reset standby", standby, 1);
    chk("R1 reset rd", rd, 0);
    chk("R1 reset reqs", sreq | rreq, 0);
    chk("R1 reset dq_oe", dq_oe, 0);
  endtask

  task automatic t_standby();
    int s0 = store_cnt, r0 = recall_cnt;
    pins(1, 0, 0, 0);
    step(4);
    chk("R1 standby others low", standby, 1);
    chk("R1 no rd/wr", rd | wr | dq_oe, 0);
    chk("R1 no reqs", (store_cnt - s0) + (recall_cnt - r0), 0);
  endtask

  task automatic t_read();
    go_idle();
    pins(0, 0, 1, 1);
    step(1);
    chk("R9 rd not yet", rd, 0);
    step(1);
    chk("R2 rd", rd, 1);
    chk("R2 dq_oe", dq_oe, 1);
    chk("R2 standby low", standby, 0);
  endtask

  task automatic t_write();
    go_idle();
    pins(0, 0, 0, 1);
    step(2);
    chk("R3 wr oe low", wr, 1);
    chk("R3 dq_oe off", dq_oe, 0);
    pins(0, 1, 0, 1);
    step(2);
    chk("R3 wr oe high", wr, 1);
    chk("R3 rd off", rd, 0);
  endtask

  task automatic t_store();
    int s0;
    go_idle();
    s0 = store_cnt;
    pins(0, 1, 0, 0);
    step(2);
    chk("R9 store not yet", sreq, 0);
    step(1);
    chk("R4 store pulse", sreq, 1);
    chk("R4 bus_off", bus_off, 1);
    step(1);
    chk("R4 pulse width", sreq, 0);
    step(10);
    chk("R6 held no retrigger", store_cnt - s0, 1);
    pins(0, 0, 0, 0);
    step(4);
    chk("R10 nop rd/wr/standby", rd | wr | standby, 0);
    pins(0, 1, 0, 0);
    step(4);
    chk("R6 reentry retriggers", store_cnt - s0, 2);
  endtask

  task automatic t_recall();
    int s0, r0;
    go_idle();
    s0 = store_cnt; r0 = recall_cnt;
    pins(0, 0, 1, 0);
    step(3);
    chk("R5 recall pulse", rreq, 1);
    step(1);
    chk("R5 pulse width", rreq, 0);
    pins(0, 1, 0, 0);
    step(4);
    chk("R5 we low gives store", store_cnt - s0, 1);
    chk("R5 single recall", recall_cnt - r0, 1);
  endtask

  task automatic t_busy();
    int s0;
    go_idle();
    s0 = store_cnt;
    pins(0, 1, 0, 0);
    step(3);
    chk("R4 store before busy", sreq, 1);
    busy = 1'b1;
    step(1);
    chk("R8 bus_off busy", bus_off, 1);
    pins(0, 0, 1, 1);
    step(3);
    chk("R8 rd masked", rd, 0);
    chk("R8 dq_oe masked", dq_oe, 0);
    pins(0, 1, 0, 0);
    step(4);
    chk("R8 no req while busy", store_cnt - s0, 1);
    busy = 1'b0;
    step(5);
    chk("R6 held after busy", store_cnt - s0, 1);
    pins(0, 0, 1, 1);
    step(2);
    chk("R8 rd after busy", rd, 1);
    chk("R8 bus_off clear", bus_off, 0);
  endtask

  task automatic t_supply();
    int s0, r0;
    go_idle();
    supply_ok = 1'b0;
    s0 = store_cnt; r0 = recall_cnt;
    pins(0, 1, 0, 0);
    step(5);
    chk("R7 store suppressed", store_cnt - s0, 0);
    pins(0, 0, 1, 0);
    step(5);
    chk("R7 recall allowed", recall_cnt - r0, 1);
    supply_ok = 1'b1;
    go_idle();
  endtask

  task automatic t_nop();
    int s0, r0;
    go_idle();
    s0 = store_cnt; r0 = recall_cnt;
    pins(0, 1, 1, 0);
    step(4);
    chk("R10 nv nop outputs", rd | wr | standby | dq_oe, 0);
    pins(0, 1, 1, 1);
    step(4);
    chk("R10 sram nop outputs", rd | wr | standby | dq_oe, 0);
    chk("R10 no reqs", (store_cnt - s0) + (recall_cnt - r0), 0);
  endtask

  initial begin
    #(5.0 * 100000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(4);
    t_reset();
    t_standby();
    t_read();
    t_write();
    t_store();
    t_recall();
    t_busy();
    t_supply();
    t_nop();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule